// File: doc/BRIEF.md
# Motor Driver Two-Wire Register Target

This block is the register front end of a small H-bridge motor driver. It listens on an I2C bus as a target device, oversampling SCL and SDA on the system clock. It recognises START and STOP conditions, matches its own 7-bit bus address and acknowledges the bytes meant for it. It holds a drive-setting register whose fields feed the bridge and the output-voltage regulator. It also reports the live status bits from the fault supervisor. Writing a 1 to the top bit of the status register emits a single-cycle clear strobe towards that supervisor.

The bus address is picked by two straps. Each strap sees a low, open or high level, and the nine combinations give nine consecutive addresses. The straps are captured during reset only. A bus master first writes a subaddress byte that sets an internal pointer. It then writes data bytes, or issues a repeated START and reads bytes back. The pointer advances after every data byte, so consecutive bytes reach consecutive registers.

Top module: `mdrv_i2c_target`

## Requirements
- R1: Strap code 2'b00 means low (level 0), 2'b01 means open (level 1), and 2'b10 or 2'b11 means high (level 2). With index = 3*level(A1) + level(A0), the 7-bit address is 0x60 + index. The 8-bit write address is therefore 0xC0 + 2*index, and the read address is that value plus 1.
- R2: The strap levels are captured while `rst` is high. A strap change after reset has no effect on the address that is acknowledged.
- R3: An address byte that does not match, including the general call address 0x00, gets no acknowledge, and the rest of that transfer has no effect.
- R4: The drive register (subaddress 0x00) resets to 0x00. It drives `vset_o` from bits 7:2, `in2_o` from bit 1 and `in1_o` from bit 0, with bytes taken MSB first.
- R5: A register changes only after its complete data byte has been received and acknowledged. A STOP in the middle of a byte leaves the register unchanged.
- R6: A read returns the register chosen by the most recent subaddress write, MSB first. The status register (subaddress 0x01) reads as {3'b000, fault_stat_i[4:0]}, so its bit 7 always reads 0.
- R7: Writing a byte with bit 7 set to subaddress 0x01 raises `clear_pulse_o` for exactly one clock. A byte with bit 7 clear raises no pulse.
- R8: The pointer increments after every data byte, whether written or read. A subaddress byte or a write data byte aimed at a pointer above 0x01 gets no acknowledge and changes nothing.
- R9: SCL or SDA pulses shorter than FILT_LEN system clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low (open-drain drive) |
| strap_a0_i | input | 2 | Level code of address strap 0 |
| strap_a1_i | input | 2 | Level code of address strap 1 |
| fault_stat_i | input | 5 | Live fault status: bit 4 current-limit, 3 over-temperature, 2 undervoltage, 1 overcurrent, 0 any fault |
| vset_o | output | 6 | Output-voltage setting |
| in2_o | output | 1 | Bridge control bit 2 |
| in1_o | output | 1 | Bridge control bit 1 |
| clear_pulse_o | output | 1 | One-cycle fault-clear strobe |

## Verification
The pointer increment and the register commit happen in the same clock as the end of an acknowledge. In an auto-increment burst, that clock commits one byte to the drive register and also readies the next byte, which raises the clear strobe. The bench sends one burst of three bytes. It expects the first byte in the drive register, exactly one clear pulse from the second byte, and a missing acknowledge on the third byte. It also reads two bytes in one transfer and checks that the second byte comes from the status register.

// File: rtl/mdrv_i2c_pkg.sv
package mdrv_i2c_pkg;

    localparam int          BYTE_BITS  = 8;
    localparam int          NUM_REGS   = 2;
    localparam logic [7:0]  REG_DRIVE  = 8'h00;
    localparam logic [7:0]  REG_STATUS = 8'h01;
    localparam int          CLR_BIT    = 7;
    localparam logic [6:0]  BASE_ADDR7 = 7'h60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } xfer_state_t;

    typedef struct packed {
        logic [5:0] vset;
        logic       in2;
        logic       in1;
    } drive_reg_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic       en;
    } wr_req_t;

    // three-level strap code to level 0..2 (2'b11 treated as high)
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        return (code == 2'b11) ? 2'd2 : code;
    endfunction

    function automatic logic [6:0] strap_addr7(input logic [1:0] a1, input logic [1:0] a0);
        logic [6:0] l1;
        logic [6:0] l0;
        l1 = {5'd0, strap_level(a1)};
        l0 = {5'd0, strap_level(a0)};
        return BASE_ADDR7 + (l1 * 7'd3) + l0;
    endfunction

endpackage

// File: rtl/mdrv_line_cond.sv
module mdrv_line_cond #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            filt_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == filt_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                run_q  <= '0;
                filt_o <= sync_q[1];
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R9: the filtered level only moves to a level the synchronizer held
    assert_filter_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (filt_o != $past(filt_o)) |-> (filt_o == $past(sync_q[1])));

endmodule

// File: rtl/mdrv_i2c_fsm.sv
module mdrv_i2c_fsm
    import mdrv_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [6:0] my_addr7,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       sda_oe,
    output wr_req_t    wr_req
);
    localparam logic [3:0] LAST = 4'(BYTE_BITS);

    xfer_state_t state;
    logic        scl_q, sda_q;
    logic [3:0]  cnt;
    logic [7:0]  shreg, tx, ptr;
    logic        in_ack, m_ack, accept;
    logic [2:0]  bit_sel;

    wire ev_start = scl_f & scl_q & sda_q & ~sda_f;
    wire ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
    wire ev_rise  = scl_f & ~scl_q;
    wire ev_fall  = ~scl_f & scl_q;

    assign rd_addr = ptr;
    assign bit_sel = 3'(4'd7 - cnt);

    always_comb begin
        unique case (state)
            ST_ADDR:  accept = (shreg[7:1] == my_addr7);
            ST_SUB:   accept = (shreg < 8'(NUM_REGS));
            ST_WDATA: accept = (ptr < 8'(NUM_REGS));
            default:  accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            cnt    <= '0;
            shreg  <= '0;
            tx     <= '0;
            ptr    <= '0;
            in_ack <= 1'b0;
            m_ack  <= 1'b0;
            sda_oe <= 1'b0;
            wr_req <= '0;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            wr_req.en <= 1'b0;
            if (ev_stop) begin
                state  <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev_start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (state inside {ST_ADDR, ST_SUB, ST_WDATA}) begin
                if (ev_rise && !in_ack) begin
                    shreg <= {shreg[6:0], sda_f};
                    cnt   <= cnt + 1'b1;
                end else if (ev_fall && !in_ack && cnt == LAST) begin
                    if (accept) begin
                        in_ack <= 1'b1;
                        sda_oe <= 1'b1;
                    end else begin
                        state <= ST_HOLD;
                    end
                end else if (ev_fall && in_ack) begin
                    in_ack <= 1'b0;
                    sda_oe <= 1'b0;
                    cnt    <= '0;
                    unique case (state)
                        ST_ADDR: begin
                            if (shreg[0]) begin
                                state  <= ST_RDATA;
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state <= ST_SUB;
                            end
                        end
                        ST_SUB: begin
                            ptr   <= shreg;
                            state <= ST_WDATA;
                        end
                        default: begin
                            wr_req <= '{addr: ptr, data: shreg, en: 1'b1};
                            ptr    <= ptr + 1'b1;
                        end
                    endcase
                end
            end else if (state == ST_RDATA) begin
                if (ev_rise) begin
                    if (in_ack) m_ack <= ~sda_f;
                    else        cnt   <= cnt + 1'b1;
                end else if (ev_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        if (m_ack) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                        end else begin
                            state <= ST_HOLD;
                        end
                    end else if (cnt == LAST) begin
                        sda_oe <= 1'b0;
                        in_ack <= 1'b1;
                        ptr    <= ptr + 1'b1;
                    end else begin
                        sda_oe <= ~tx[bit_sel];
                    end
                end
            end
        end
    end

    // R3: the target never pulls the line while idle
    assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R8: a write strobe never targets a register beyond the map
    assert_write_in_map_R8: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> (wr_req.addr < 8'(NUM_REGS)));

    // R5: commits come only out of the data phase
    assert_commit_from_data_R5: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> ($past(state) == ST_WDATA));

endmodule

// File: rtl/mdrv_reg_bank.sv
module mdrv_reg_bank
    import mdrv_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr_req,
    input  logic [7:0] rd_addr,
    input  logic [4:0] status_i,
    output logic [7:0] rd_data,
    output drive_reg_t drive_q,
    output logic       clear_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q     <= '0;
            clear_pulse <= 1'b0;
        end else begin
            clear_pulse <= 1'b0;
            if (wr_req.en) begin
                if (wr_req.addr == REG_DRIVE)  drive_q     <= drive_reg_t'(wr_req.data);
                if (wr_req.addr == REG_STATUS) clear_pulse <= wr_req.data[CLR_BIT];
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            REG_DRIVE:  rd_data = drive_q;
            REG_STATUS: rd_data = {3'b000, status_i};
            default:    rd_data = 8'h00;
        endcase
    end

    // R7: the clear strobe lasts one cycle
    assert_clear_single_R7: assert property (@(posedge clk) disable iff (rst)
        clear_pulse |=> !clear_pulse);

    // R5: the drive register holds unless a commit arrives
    assert_drive_holds_R5: assert property (@(posedge clk) disable iff (rst)
        !wr_req.en |=> $stable(drive_q));

endmodule

// File: rtl/mdrv_i2c_target.sv
module mdrv_i2c_target
    import mdrv_i2c_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_a0_i,
    input  logic [1:0] strap_a1_i,
    input  logic [4:0] fault_stat_i,
    output logic [5:0] vset_o,
    output logic       in2_o,
    output logic       in1_o,
    output logic       clear_pulse_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic [6:0]        addr7;
    logic [7:0]        rd_addr, rd_data;
    wr_req_t           wr_req;
    drive_reg_t        drive_q;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        mdrv_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) addr7 <= strap_addr7(strap_a1_i, strap_a0_i);
    end

    mdrv_i2c_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .my_addr7 (addr7),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .sda_oe   (sda_oe_o),
        .wr_req   (wr_req)
    );

    mdrv_reg_bank u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_req      (wr_req),
        .rd_addr     (rd_addr),
        .status_i    (fault_stat_i),
        .rd_data     (rd_data),
        .drive_q     (drive_q),
        .clear_pulse (clear_pulse_o)
    );

    assign vset_o = drive_q.vset;
    assign in2_o  = drive_q.in2;
    assign in1_o  = drive_q.in1;

    // R2: the captured address never moves outside reset
    assert_addr_latched_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(addr7));

    // R1/R3: the captured address lies in the strap range, never general call
    assert_addr_range_R1: assert property (@(posedge clk) disable iff (rst)
        (addr7 >= BASE_ADDR7) && (addr7 <= BASE_ADDR7 + 7'd8));

endmodule

// File: tb/tb_mdrv_i2c_target.sv
`timescale 1ns/1ps
module tb_mdrv_i2c_target;

    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] a0 = 2'b10, a1 = 2'b01;
    logic [4:0] stat = 5'd0;
    logic       sda_oe, in1, in2, clr;
    logic [5:0] vset;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0, failures = 0, pulses = 0;
    bit done = 0, wide = 0;

    always #2.5 clk = ~clk;

    mdrv_i2c_target dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_a0_i(a0), .strap_a1_i(a1), .fault_stat_i(stat),
        .vset_o(vset), .in2_o(in2), .in1_o(in1), .clear_pulse_o(clr)
    );

    logic clr_d = 1'b0;
    always @(posedge clk) begin
        clr_d <= clr;
        if (clr) pulses++;
        if (clr && clr_d) wide = 1;
    end

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] sub;
        logic [7:0] data;
        logic [2:0] acks;
        logic [7:0] drive;
        logic       pulse;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'hCA, 8'h00, 8'hA5, 3'b111, 8'hA5, 1'b0},  // R4 R1
        '{8'hCA, 8'h00, 8'hFF, 3'b111, 8'hFF, 1'b0},  // R4
        '{8'hCC, 8'h00, 8'h12, 3'b000, 8'hFF, 1'b0},  // R3 other address
        '{8'h00, 8'h00, 8'h33, 3'b000, 8'hFF, 1'b0},  // R3 general call
        '{8'hCA, 8'h02, 8'h44, 3'b100, 8'hFF, 1'b0},  // R8 sub out of map
        '{8'hCA, 8'h00, 8'h3C, 3'b111, 8'h3C, 1'b0},  // R4
        '{8'hCA, 8'h01, 8'h80, 3'b111, 8'h3C, 1'b1},  // R7 clear
        '{8'hCA, 8'h01, 8'h1F, 3'b111, 8'h3C, 1'b0}   // R7 no clear
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b0; tick(T);
        scl_m = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(T);
        scl_m = 1'b1; tick(T);
        sda_m = 1'b1; tick(T);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(T);
            scl_m = 1'b1; tick(T / 2);
            if (glitch && i == 4) begin
                scl_m = 1'b0; tick(2);
                scl_m = 1'b1;
            end
            tick(T / 2);
            scl_m = 1'b0; tick(3);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        sda_m = 1'b1; tick(T);
        scl_m = 1'b1; tick(T / 2);
        ack = ~sda_line;
        tick(T / 2);
        scl_m = 1'b0; tick(3);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(T);
            scl_m = 1'b1; tick(T / 2);
            b[i] = sda_line;
            tick(T / 2);
            scl_m = 1'b0; tick(3);
        end
        sda_m = ~give_ack; tick(T);
        scl_m = 1'b1; tick(T);
        scl_m = 1'b0; tick(3);
        sda_m = 1'b1;
    endtask

    task automatic chk_drive(input string req, input logic [7:0] exp);
        chk(req, {24'd0, vset, in2, in1}, {24'd0, exp});
    endtask

    initial begin
        bit         k0, k1, k2;
        logic [7:0] rb, rb2;
        int         p0;

        tick(10);
        rst = 1'b0;
        tick(5);
        // R4 reset state
        chk_drive("R4 reset drive", 8'h00);
        chk("R4 reset line released", {31'd0, sda_oe}, 32'd0);
        chk("R7 reset no clear", {31'd0, clr}, 32'd0);

        // table walk
        for (int v = 0; v < 8; v++) begin
            p0 = pulses;
            bus_start();
            send_byte(VECS[v].addr, 1'b0, k0);
            send_byte(VECS[v].sub, 1'b0, k1);
            send_byte(VECS[v].data, 1'b0, k2);
            bus_stop();
            tick(10);
            chk($sformatf("R3/R8 acks vec%0d", v), {29'd0, k0, k1, k2}, {29'd0, VECS[v].acks});
            chk_drive($sformatf("R4/R5 drive vec%0d", v), VECS[v].drive);
            chk($sformatf("R7 pulses vec%0d", v), pulses - p0, {31'd0, VECS[v].pulse});
        end
        chk("R7 pulse width one", {31'd0, wide}, 32'd0);

        // R6 read of status register
        stat = 5'b10110;
        bus_start();
        send_byte(8'hCA, 1'b0, k0);
        send_byte(8'h01, 1'b0, k1);
        bus_start();
        send_byte(8'hCB, 1'b0, k2);
        recv_byte(1'b0, rb);
        bus_stop();
        chk("R6 status read acks", {29'd0, k0, k1, k2}, 32'd7);
        chk("R6 status read value", {24'd0, rb}, 32'h16);

        // R6 R8 two-byte read with auto increment
        stat = 5'b00011;
        bus_start();
        send_byte(8'hCA, 1'b0, k0);
        send_byte(8'h00, 1'b0, k1);
        bus_start();
        send_byte(8'hCB, 1'b0, k2);
        recv_byte(1'b1, rb);
        recv_byte(1'b0, rb2);
        bus_stop();
        chk("R6 drive read value", {24'd0, rb}, 32'h3C);
        chk("R8 read auto-increment", {24'd0, rb2}, 32'h03);

        // R8 R7 write burst: drive, clear, then out of map
        p0 = pulses;
        bus_start();
        send_byte(8'hCA, 1'b0, k0);
        send_byte(8'h00, 1'b0, k1);
        send_byte(8'h55, 1'b0, k2);
        chk("R8 burst byte0 ack", {31'd0, k2}, 32'd1);
        send_byte(8'h81, 1'b0, k2);
        chk("R8 burst byte1 ack", {31'd0, k2}, 32'd1);
        send_byte(8'h77, 1'b0, k2);
        chk("R8 burst byte2 nack", {31'd0, k2}, 32'd0);
        bus_stop();
        tick(10);
        chk_drive("R8 burst drive", 8'h55);
        chk("R7 burst single pulse", pulses - p0, 32'd1);

        // R5 STOP in the middle of a data byte
        bus_start();
        send_byte(8'hCA, 1'b0, k0);
        send_byte(8'h00, 1'b0, k1);
        send_bits(8'hAA, 4, 1'b0);
        bus_stop();
        tick(10);
        chk_drive("R5 aborted byte ignored", 8'h55);

        // R9 short SCL glitch inside a bit
        bus_start();
        send_byte(8'hCA, 1'b0, k0);
        send_byte(8'h00, 1'b0, k1);
        send_byte(8'h69, 1'b1, k2);
        bus_stop();
        tick(10);
        chk("R9 glitch byte ack", {31'd0, k2}, 32'd1);
        chk_drive("R9 glitch filtered", 8'h69);

        // R2 strap change without reset is ignored
        a0 = 2'b11; a1 = 2'b10;
        tick(10);
        bus_start();
        send_byte(8'hD0, 1'b0, k0);
        bus_stop();
        chk("R2 new strap not used", {31'd0, k0}, 32'd0);
        bus_start();
        send_byte(8'hCA, 1'b0, k0);
        bus_stop();
        chk("R2 old address kept", {31'd0, k0}, 32'd1);

        // R1 new strap after reset: high/high -> index 8 -> 0xD0
        rst = 1'b1; tick(5); rst = 1'b0; tick(5);
        bus_start();
        send_byte(8'hD0, 1'b0, k0);
        send_byte(8'h00, 1'b0, k1);
        send_byte(8'h0E, 1'b0, k2);
        bus_stop();
        tick(10);
        chk("R1 strap index 8 acks", {29'd0, k0, k1, k2}, 32'd7);
        chk_drive("R1 strap index 8 write", 8'h0E);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule